// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside a memory controller's command scheduler and follows every command the controller sends to a multi-bank SDRAM. For each bank it keeps a small state machine: idle, row open, closing after an access that requested automatic precharge, or precharging. From that state it tells the scheduler, bank by bank, whether an ACTIVE would be legal in the next cycle and whether a READ or WRITE would be legal. It also gives the row currently open in each bank, so the scheduler can detect page hits.

Banks are fully independent. Any number of banks may have a row open at once, and a command to one bank never disturbs another. A precharge, whether explicit or triggered automatically after an access, starts a per-bank countdown. The bank may not be activated again until that countdown has expired. A PRECHARGE with the all-banks bit set closes every bank that holds a row, and their timers run together.

Every command the tracker sees is also checked. A READ or WRITE to a bank with no open row, an ACTIVE to a bank that still holds a row, and an ACTIVE that arrives before the precharge time is over are each reported as a one-cycle error with a kind code. An illegal command changes no state.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank is idle: all `act_ready` bits are 1, all `rw_ready` bits are 0, and `cmd_error` is 0.
- R2: An ACTIVE (`cmd_op`=1) to a bank whose `act_ready` is 1 opens that bank at the clock edge that samples it. From the next cycle that bank shows `rw_ready`=1 and `act_ready`=0, and its slice of `open_rows` (bits b*ROW_W and up) equals `cmd_row`.
- R3: A command addressed to one bank leaves the ready flags and open row of every other bank unchanged, so several banks can hold open rows at the same time.
- R4: A READ (`cmd_op`=2) or WRITE (`cmd_op`=3) to an open bank with `cmd_auto_pre`=0 leaves the bank open, and back-to-back accesses stay legal.
- R5: A PRECHARGE (`cmd_op`=4, `cmd_all_banks`=0) to an open bank clears its `rw_ready` in the next cycle. An ACTIVE to that bank is legal when sampled T_RP edges after the PRECHARGE, and illegal one edge earlier.
- R6: A READ or WRITE with `cmd_auto_pre`=1 closes the bank with no further command. `rw_ready` drops in the next cycle, and an ACTIVE becomes legal AP_DELAY+T_RP edges after the access.
- R7: A PRECHARGE with `cmd_all_banks`=1 ignores `cmd_bank` and closes every bank that holds a row, starting all of their timers on the same edge. Idle banks stay activate-ready.
- R8: A READ or WRITE to a bank whose `rw_ready` is 0 raises `cmd_error` for one cycle with `error_kind`=1 and changes no bank state.
- R9: An ACTIVE to a bank that is open or still closing after an auto-precharge access raises `cmd_error` with `error_kind`=2 and leaves that bank's open row unchanged.
- R10: An ACTIVE to a bank whose precharge time has not yet elapsed raises `cmd_error` with `error_kind`=3 and leaves the bank unopened.
- R11: A PRECHARGE to an idle bank, a NOP (`cmd_op`=0) and any unused opcode (5 to 7) have no effect and raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command opcode: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE |
| cmd_bank | input | BANK_W | Target bank of the command |
| cmd_row | input | ROW_W | Row address carried by ACTIVE |
| cmd_auto_pre | input | 1 | Auto-precharge request on READ/WRITE |
| cmd_all_banks | input | 1 | All-banks select on PRECHARGE |
| act_ready | output | NUM_BANKS | Per bank: an ACTIVE sampled at the next edge is legal |
| rw_ready | output | NUM_BANKS | Per bank: a READ/WRITE sampled at the next edge is legal |
| open_rows | output | NUM_BANKS*ROW_W | Open row of each bank, bank b in bits b*ROW_W upward |
| cmd_error | output | 1 | One-cycle pulse after an illegal command |
| error_kind | output | 2 | Error cause: 1 access to a closed bank, 2 activate to a held row, 3 activate too early |

## Verification
On every cycle the embedded properties check several things. A bank never gains an open row without an activate. A bank still counting its precharge time never opens. A closing bank never reports itself accessible. The open row never shifts while a bank stays accessible. A precharge-all always clears every access flag, and each illegal access or early activate is flagged with the right kind. The exact lengths of the precharge and auto-precharge windows, counted edge by edge, can only be shown by the bench's scenarios. The same holds for the independence of banks across interleaved commands and the row values seen at the ports.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_ACT   = 3'd1,
      OP_READ  = 3'd2,
      OP_WRITE = 3'd3,
      OP_PRE   = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      BK_IDLE,
      BK_OPEN,
      BK_CLOSING,
      BK_PRECHG
   } bank_st_e;

   typedef enum logic [1:0] {
      ERR_NONE      = 2'd0,
      ERR_RW_CLOSED = 2'd1,
      ERR_ACT_HELD  = 2'd2,
      ERR_ACT_EARLY = 2'd3
   } err_e;

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
   import sbt_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
) (
   input  logic [2:0]           op_i,
   input  logic [BANK_W-1:0]    bank_i,
   input  logic                 auto_pre_i,
   input  logic                 all_banks_i,
   output logic [NUM_BANKS-1:0] act_sel_o,
   output logic [NUM_BANKS-1:0] rw_sel_o,
   output logic [NUM_BANKS-1:0] pre_sel_o,
   output logic                 ap_o
);

   logic is_act, is_rw, is_pre;

   always_comb begin
      is_act = (op_i == OP_ACT);
      is_rw  = (op_i == OP_READ) || (op_i == OP_WRITE);
      is_pre = (op_i == OP_PRE);
      ap_o   = is_rw && auto_pre_i;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
      logic hit;
      assign hit          = (bank_i == BANK_W'(b));
      assign act_sel_o[b] = is_act && hit;
      assign rw_sel_o[b]  = is_rw && hit;
      assign pre_sel_o[b] = is_pre && (hit || all_banks_i);
   end

endmodule

// File: rtl/sbt_bank_fsm.sv
module sbt_bank_fsm
   import sbt_pkg::*;
#(
   parameter int ROW_W    = 13,
   parameter int T_RP     = 3,
   parameter int AP_DELAY = 2,
   localparam int CNT_MAX = (T_RP > AP_DELAY) ? T_RP : AP_DELAY,
   localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             rw_i,
   input  logic             ap_i,
   input  logic             pre_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             act_ready_o,
   output logic             rw_ready_o,
   output logic             row_held_o,
   output logic [ROW_W-1:0] open_row_o
);

   localparam logic [CNT_W-1:0] RP_LOAD = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] AP_LOAD = CNT_W'(AP_DELAY - 1);

   bank_st_e         st;
   logic [CNT_W-1:0] cnt;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= BK_IDLE;
         cnt   <= '0;
         row_q <= '0;
      end else begin
         unique case (st)
            BK_IDLE: begin
               if (act_i) begin
                  st    <= BK_OPEN;
                  row_q <= row_i;
               end
            end
            BK_OPEN: begin
               if (pre_i) begin
                  st  <= BK_PRECHG;
                  cnt <= RP_LOAD;
               end else if (rw_i && ap_i) begin
                  st  <= BK_CLOSING;
                  cnt <= AP_LOAD;
               end
            end
            BK_CLOSING: begin
               if (pre_i || cnt == '0) begin
                  st  <= BK_PRECHG;
                  cnt <= RP_LOAD;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            BK_PRECHG: begin
               if (cnt == '0) begin
                  if (act_i) begin
                     st    <= BK_OPEN;
                     row_q <= row_i;
                  end else begin
                     st <= BK_IDLE;
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: st <= BK_IDLE;
         endcase
      end
   end

   assign act_ready_o = (st == BK_IDLE) || (st == BK_PRECHG && cnt == '0);
   assign rw_ready_o  = (st == BK_OPEN);
   assign row_held_o  = (st == BK_OPEN) || (st == BK_CLOSING);
   assign open_row_o  = row_q;

   // R2: a bank only becomes accessible through an activate
   assert_open_needs_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rw_ready_o) |-> $past(act_i));

   // R5: no bank opens while its precharge countdown is still running
   assert_rp_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BK_PRECHG && cnt != '0) |=> !rw_ready_o);

   // R6: a bank closing after auto-precharge never reports itself accessible
   assert_closing_shut_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BK_CLOSING) |=> !rw_ready_o);

   // R3: the open row stays put as long as the bank stays accessible
   assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rw_ready_o |=> (!rw_ready_o || $stable(open_row_o)));

endmodule

// File: rtl/sbt_err_check.sv
module sbt_err_check
   import sbt_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter bit ERR_REG   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           op_i,
   input  logic [BANK_W-1:0]    bank_i,
   input  logic [NUM_BANKS-1:0] act_ready_i,
   input  logic [NUM_BANKS-1:0] rw_ready_i,
   input  logic [NUM_BANKS-1:0] row_held_i,
   output logic                 err_o,
   output logic [1:0]           kind_o
);

   logic is_act, is_rw;
   err_e kind_d;

   always_comb begin
      is_act = (op_i == OP_ACT);
      is_rw  = (op_i == OP_READ) || (op_i == OP_WRITE);
      kind_d = ERR_NONE;
      if (is_rw && !rw_ready_i[bank_i])
         kind_d = ERR_RW_CLOSED;
      else if (is_act && row_held_i[bank_i])
         kind_d = ERR_ACT_HELD;
      else if (is_act && !act_ready_i[bank_i])
         kind_d = ERR_ACT_EARLY;
   end

   if (ERR_REG) begin : g_reg
      err_e kind_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) kind_q <= ERR_NONE;
         else        kind_q <= kind_d;
      end
      assign kind_o = kind_q;

      // R8: an access to a bank without an open row is reported as kind 1
      assert_rw_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (is_rw && !rw_ready_i[bank_i]) |=> (err_o && kind_o == 2'd1));

      // R10: an activate inside the precharge window is reported as kind 3
      assert_act_early_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (is_act && !act_ready_i[bank_i] && !row_held_i[bank_i]) |=> (err_o && kind_o == 2'd3));
   end else begin : g_comb
      assign kind_o = kind_d;
   end

   assign err_o = (kind_o != 2'd0);

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
   import sbt_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   parameter int T_RP      = 3,
   parameter int AP_DELAY  = 2,
   parameter bit ERR_REG   = 1'b1,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [2:0]                 cmd_op,
   input  logic [BANK_W-1:0]          cmd_bank,
   input  logic [ROW_W-1:0]           cmd_row,
   input  logic                       cmd_auto_pre,
   input  logic                       cmd_all_banks,
   output logic [NUM_BANKS-1:0]       act_ready,
   output logic [NUM_BANKS-1:0]       rw_ready,
   output logic [NUM_BANKS*ROW_W-1:0] open_rows,
   output logic                       cmd_error,
   output logic [1:0]                 error_kind
);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (T_RP < 1) begin : g_bad_trp
      $error("T_RP must be at least 1");
   end
   if (AP_DELAY < 1) begin : g_bad_ap
      $error("AP_DELAY must be at least 1");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("ROW_W must be at least 1");
   end

   logic [NUM_BANKS-1:0] act_sel, rw_sel, pre_sel, row_held;
   logic                 ap;

   sbt_cmd_decode #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_decode (
      .op_i        (cmd_op),
      .bank_i      (cmd_bank),
      .auto_pre_i  (cmd_auto_pre),
      .all_banks_i (cmd_all_banks),
      .act_sel_o   (act_sel),
      .rw_sel_o    (rw_sel),
      .pre_sel_o   (pre_sel),
      .ap_o        (ap)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sbt_bank_fsm #(
         .ROW_W    (ROW_W),
         .T_RP     (T_RP),
         .AP_DELAY (AP_DELAY)
      ) u_fsm (
         .clk         (clk),
         .rst_n       (rst_n),
         .act_i       (act_sel[b]),
         .rw_i        (rw_sel[b]),
         .ap_i        (ap),
         .pre_i       (pre_sel[b]),
         .row_i       (cmd_row),
         .act_ready_o (act_ready[b]),
         .rw_ready_o  (rw_ready[b]),
         .row_held_o  (row_held[b]),
         .open_row_o  (open_rows[b*ROW_W +: ROW_W])
      );
   end

   sbt_err_check #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .ERR_REG   (ERR_REG)
   ) u_err (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (cmd_op),
      .bank_i      (cmd_bank),
      .act_ready_i (act_ready),
      .rw_ready_i  (rw_ready),
      .row_held_i  (row_held),
      .err_o       (cmd_error),
      .kind_o      (error_kind)
   );

   // R7: a precharge-all leaves no bank accessible
   assert_pre_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd4 && cmd_all_banks) |=> (rw_ready == '0));

   // R1: a bank is never ready for both activate and access at once
   assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ready & rw_ready) == '0);

endmodule

// File: tb/sdram_bank_tracker_tb_top.sv
module sdram_bank_tracker_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB         = 4;
   localparam int RW         = 13;
   localparam int TRP        = 3;
   localparam int APD        = 2;
   localparam int NVEC       = 20;

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  bank;
      logic [12:0] row;
      logic        ap;
      logic        all;
      logic [3:0]  act;
      logic [3:0]  rw;
      logic        err;
      logic [1:0]  kind;
      logic [3:0]  req;
   } vec_t;

   function automatic vec_t mk(int op, int bank, int row, int ap, int all,
                               int act, int rw, int err, int kind, int req);
      vec_t v;
      v.op = 3'(op);   v.bank = 2'(bank); v.row = 13'(row);
      v.ap = 1'(ap);   v.all = 1'(all);   v.act = 4'(act);
      v.rw = 4'(rw);   v.err = 1'(err);   v.kind = 2'(kind);
      v.req = 4'(req);
      return v;
   endfunction

   // op: 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 PRE; expectations hold after the sampling edge
   localparam vec_t TBL [NVEC] = '{
      mk(1, 0, 'h011, 0, 0, 'b1110, 'b0001, 0, 0, 2),  // R2 open bank 0
      mk(1, 2, 'h022, 0, 0, 'b1010, 'b0101, 0, 0, 3),  // R3 second bank open too
      mk(2, 0, 0,     0, 0, 'b1010, 'b0101, 0, 0, 4),  // R4 read keeps open
      mk(3, 2, 0,     0, 0, 'b1010, 'b0101, 0, 0, 4),  // R4 write keeps open
      mk(2, 1, 0,     0, 0, 'b1010, 'b0101, 1, 1, 8),  // R8 read to idle bank
      mk(1, 0, 'h055, 0, 0, 'b1010, 'b0101, 1, 2, 9),  // R9 activate open bank
      mk(4, 0, 0,     0, 0, 'b1010, 'b0100, 0, 0, 5),  // R5 precharge bank 0
      mk(1, 0, 'h066, 0, 0, 'b1010, 'b0100, 1, 3, 10), // R10 activate too early
      mk(0, 0, 0,     0, 0, 'b1011, 'b0100, 0, 0, 5),  // R5 ready after T_RP
      mk(1, 0, 'h033, 0, 0, 'b1010, 'b0101, 0, 0, 5),  // R5 activate at boundary
      mk(2, 2, 0,     1, 0, 'b1010, 'b0001, 0, 0, 6),  // R6 read with auto-precharge
      mk(0, 0, 0,     0, 0, 'b1010, 'b0001, 0, 0, 6),  // R6 closing
      mk(0, 0, 0,     0, 0, 'b1010, 'b0001, 0, 0, 6),  // R6 precharging
      mk(0, 0, 0,     0, 0, 'b1010, 'b0001, 0, 0, 6),  // R6 one edge early
      mk(0, 0, 0,     0, 0, 'b1110, 'b0001, 0, 0, 6),  // R6 ready after AP_DELAY+T_RP
      mk(1, 3, 'h044, 0, 0, 'b0110, 'b1001, 0, 0, 3),  // R3 open bank 3
      mk(4, 1, 0,     0, 1, 'b0110, 'b0000, 0, 0, 7),  // R7 precharge all
      mk(0, 0, 0,     0, 0, 'b0110, 'b0000, 0, 0, 7),  // R7 timers running
      mk(0, 0, 0,     0, 0, 'b1111, 'b0000, 0, 0, 7),  // R7 all ready together
      mk(4, 1, 0,     0, 0, 'b1111, 'b0000, 0, 0, 11)  // R11 precharge idle bank
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [2:0]     cmd_op = '0;
   logic [1:0]     cmd_bank = '0;
   logic [RW-1:0]  cmd_row = '0;
   logic           cmd_auto_pre = 1'b0;
   logic           cmd_all_banks = 1'b0;
   logic [NB-1:0]  act_ready, rw_ready;
   logic [NB*RW-1:0] open_rows;
   logic           cmd_error;
   logic [1:0]     error_kind;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_bank_tracker #(
      .NUM_BANKS (NB),
      .ROW_W     (RW),
      .T_RP      (TRP),
      .AP_DELAY  (APD),
      .ERR_REG   (1'b1)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_op        (cmd_op),
      .cmd_bank      (cmd_bank),
      .cmd_row       (cmd_row),
      .cmd_auto_pre  (cmd_auto_pre),
      .cmd_all_banks (cmd_all_banks),
      .act_ready     (act_ready),
      .rw_ready      (rw_ready),
      .open_rows     (open_rows),
      .cmd_error     (cmd_error),
      .error_kind    (error_kind)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // called at a falling edge; returns one falling edge later
   task automatic issue(int op, int bank, int row, int ap, int all);
      cmd_op = 3'(op); cmd_bank = 2'(bank); cmd_row = RW'(row);
      cmd_auto_pre = 1'(ap); cmd_all_banks = 1'(all);
      @(negedge clk);
      cmd_op = '0; cmd_bank = '0; cmd_row = '0;
      cmd_auto_pre = 1'b0; cmd_all_banks = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [RW-1:0] row_of(int b);
      return open_rows[b*RW +: RW];
   endfunction

   initial begin
      do_reset();
      chk("R1 act_ready after reset", 32'(act_ready), 32'hF);
      chk("R1 rw_ready after reset", 32'(rw_ready), 32'h0);
      chk("R1 cmd_error after reset", 32'(cmd_error), 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         issue(TBL[i].op, TBL[i].bank, TBL[i].row, TBL[i].ap, TBL[i].all);
         chk($sformatf("R%0d vec %0d act_ready", TBL[i].req, i), 32'(act_ready), 32'(TBL[i].act));
         chk($sformatf("R%0d vec %0d rw_ready", TBL[i].req, i), 32'(rw_ready), 32'(TBL[i].rw));
         chk($sformatf("R%0d vec %0d cmd_error", TBL[i].req, i), 32'(cmd_error), 32'(TBL[i].err));
         chk($sformatf("R%0d vec %0d error_kind", TBL[i].req, i), 32'(error_kind), 32'(TBL[i].kind));
      end

      // directed: row tracking, held-row activate, closing bank, unused opcodes
      do_reset();
      chk("R1 act_ready after second reset", 32'(act_ready), 32'hF);
      issue(1, 1, 'h155, 0, 0);
      chk("R2 open row of bank 1", 32'(row_of(1)), 32'h155);
      issue(1, 1, 'h0AA, 0, 0);
      chk("R9 error on activate of open bank", 32'(error_kind), 32'd2);
      chk("R9 open row unchanged", 32'(row_of(1)), 32'h155);
      issue(1, 2, 'h1FF, 0, 0);
      chk("R3 bank 2 row", 32'(row_of(2)), 32'h1FF);
      chk("R3 bank 1 row untouched", 32'(row_of(1)), 32'h155);
      chk("R3 both banks accessible", 32'(rw_ready), 32'h6);
      issue(3, 1, 0, 1, 0);
      chk("R6 rw_ready drops after auto-precharge write", 32'(rw_ready), 32'h4);
      issue(1, 1, 'h0BB, 0, 0);
      chk("R9 activate of closing bank", 32'(error_kind), 32'd2);
      chk("R9 closing bank row unchanged", 32'(row_of(1)), 32'h155);
      issue(2, 1, 0, 0, 0);
      chk("R8 read to closing bank", 32'(error_kind), 32'd1);
      chk("R8 cmd_error pulse", 32'(cmd_error), 32'd1);
      issue(7, 2, 0, 0, 1);
      chk("R11 unused opcode no error", 32'(cmd_error), 32'd0);
      chk("R11 unused opcode keeps bank 2 open", 32'(rw_ready[2]), 32'd1);
      chk("R11 unused opcode keeps bank 2 row", 32'(row_of(2)), 32'h1FF);
      issue(0, 0, 0, 0, 0);
      chk("R8 error pulse lasts one cycle", 32'(cmd_error), 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule